// File: doc/BRIEF.md
# DRAM ECC Error Event Logger

This block sits beside a memory controller's ECC correction logic and keeps a record of the faults it reports. It receives correctable and uncorrectable error pulses. Each pulse comes with the failing line address, a channel number and an 8-bit syndrome. It also receives pulses for refresh timeouts, for locked accesses that reach non-DRAM space, and for thermal sensor trips. Each event sets a sticky bit in a 16-bit status register. Software clears a status bit by writing a 1 to it.

The first memory error is logged with its location and syndrome, and so is an uncorrectable error that follows a correctable one. Any other later error leaves the logged record in place. A 16-bit enable register, laid out like the status register, selects which events raise a one-cycle system-error pulse. Software reaches all of this through a byte-offset register port with single-cycle read and write strobes. The port returns read data one cycle after the strobe.

Top module: `ecc_err_log`

## Requirements
- R1: After a synchronous reset, every register reads zero, and `serr` and `rd_valid` are low.
- R2: The status register (offset 0xC8, read in `rd_data[15:0]`) maps events to bits as follows: correctable error to bit 0, uncorrectable error to bit 1, refresh timeout to bit 8, non-DRAM locked access to bit 9, thermal event to bit 11. An event pulse sets its bit at the next clock edge. All other bits read zero.
- R3: A write to offset 0xC8 clears each status bit whose `wr_data` bit is 1, within the mask 0x0B03. Bits written with 0 keep their value.
- R4: When an event pulse and a write-1 clear hit the same status bit in the same cycle, the bit stays set.
- R5: The address pointer (offset 0x58) holds line address bits 31:7 in bits 31:7 and the channel in bit 0, with bits 6:1 read as zero. The extended pointer (offset 0x70) holds address bit 32 in bit 0, with all other bits zero. `err_line` carries address bits 32:7, so `err_line[0]` is address bit 7.
- R6: The syndrome register (offset 0x5C) holds the logged error's syndrome in bits 7:0.
- R7: An error's address, channel and syndrome are captured when neither error bit (1:0) is still set after the clear applied in that cycle.
- R8: An uncorrectable error replaces a logged correctable error's fields. A correctable error never replaces logged fields, and a second uncorrectable error never replaces the first. If both pulses arrive in one cycle, they are treated as one uncorrectable error.
- R9: The enable register (offset 0xCA) is written from `wr_data` and reads back only bits 0, 1, 8, 9 and 11. Its other bits read zero.
- R10: `serr` is high for exactly the one cycle after a clock edge at which some status bit goes from 0 to 1 while its enable bit, as held before that edge, is set. No pulse occurs for a bit that was already set or is disabled.
- R11: A read strobe yields `rd_valid` and `rd_data` one cycle later, showing register values from before the strobe's edge. Unmapped offsets read zero. Writes to offsets other than 0xC8 and 0xCA change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_evt | input | 1 | Correctable ECC error pulse |
| ue_evt | input | 1 | Uncorrectable ECC error pulse |
| err_line | input | LINE_W (26) | Failing address bits 32:7 |
| err_chan | input | 1 | Failing channel |
| err_syn | input | SYN_W (8) | ECC syndrome |
| rfto_evt | input | 1 | Refresh timeout pulse |
| lock_evt | input | 1 | Locked access to non-DRAM pulse |
| therm_evt | input | 1 | Thermal sensor event pulse |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| wr_data | input | 16 | Write data |
| rd_data | output | 32 | Read data, registered |
| rd_valid | output | 1 | Read data valid |
| serr | output | 1 | System error pulse |

## Verification
Status, enables and captured fields change at the clock edge that samples their stimulus, so software sees them on a read issued in any later cycle. `serr` and `rd_valid` with `rd_data` appear one cycle after the edge that samples the event or strobe. The bench drives inputs on the falling edge. Before each rising edge, its model computes the expected `serr` and read data from the pre-edge register state. It samples the outputs at the following falling edge, once that one register stage has settled.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam logic [7:0]  OFS_PTR  = 8'h58;
  localparam logic [7:0]  OFS_SYN  = 8'h5C;
  localparam logic [7:0]  OFS_EXT  = 8'h70;
  localparam logic [7:0]  OFS_STAT = 8'hC8;
  localparam logic [7:0]  OFS_ENA  = 8'hCA;
  localparam int          B_CE     = 0;
  localparam int          B_UE     = 1;
  localparam int          B_RFTO   = 8;
  localparam int          B_LOCK   = 9;
  localparam int          B_THERM  = 11;
  localparam logic [15:0] EVT_MASK = 16'h0B03;
endpackage

// File: rtl/ecc_stat_reg.sv
module ecc_stat_reg
  import ecc_log_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] ev,
  input  logic [REG_W-1:0] clr,
  input  logic [REG_W-1:0] ena,
  output logic [REG_W-1:0] stat_q,
  output logic [REG_W-1:0] stat_post,
  output logic             serr
);
  logic [REG_W-1:0] stat_nxt;

  always_comb begin
    stat_post = stat_q & ~clr;
    stat_nxt  = (stat_post | ev) & EVT_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      serr   <= 1'b0;
    end else begin
      stat_q <= stat_nxt;
      serr   <= |(stat_nxt & ~stat_q & ena);
    end
  end

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (stat_q & ~EVT_MASK) == '0);
  p_event_set_r2: assert property (@(posedge clk) disable iff (rst)
    ev[B_UE] |=> stat_q[B_UE]);
  p_event_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (ev[B_CE] && clr[B_CE]) |=> stat_q[B_CE]);
  p_serr_cause_r10: assert property (@(posedge clk) disable iff (rst)
    serr |-> ((stat_q & ~$past(stat_q)) != '0));
endmodule

// File: rtl/ecc_capture.sv
module ecc_capture #(
  parameter int LINE_W = 26,
  parameter int SYN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              ue,
  input  logic [LINE_W-1:0] line_i,
  input  logic              chan_i,
  input  logic [SYN_W-1:0]  syn_i,
  input  logic [1:0]        logged,
  output logic [LINE_W-1:0] line_q,
  output logic              chan_q,
  output logic [SYN_W-1:0]  syn_q
);
  logic take;

  always_comb begin
    if (ue) take = !logged[1];
    else    take = ce && (logged == 2'b00);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
      chan_q <= 1'b0;
      syn_q  <= '0;
    end else if (take) begin
      line_q <= line_i;
      chan_q <= chan_i;
      syn_q  <= syn_i;
    end
  end

  p_ue_keeps_r8: assert property (@(posedge clk) disable iff (rst)
    logged[1] |=> ($stable(syn_q) && $stable(line_q) && $stable(chan_q)));
  p_ce_no_take_r8: assert property (@(posedge clk) disable iff (rst)
    (!ue && logged != 2'b00) |=> $stable(line_q));
endmodule

// File: rtl/ecc_reg_port.sv
module ecc_reg_port
  import ecc_log_pkg::*;
#(
  parameter int LINE_W = 26,
  parameter int SYN_W  = 8,
  parameter int REG_W  = 16,
  parameter int RD_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        reg_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [REG_W-1:0]  stat_q,
  input  logic [LINE_W-1:0] line_q,
  input  logic              chan_q,
  input  logic [SYN_W-1:0]  syn_q,
  output logic [REG_W-1:0]  clr,
  output logic [REG_W-1:0]  ena_q,
  output logic [RD_W-1:0]   rd_data,
  output logic              rd_valid
);
  localparam int LO_W = LINE_W - 1;
  logic [RD_W-1:0] rd_mux;

  always_comb begin
    clr = (wr_en && reg_addr == OFS_STAT) ? (wr_data & EVT_MASK) : '0;
    unique case (reg_addr)
      OFS_PTR:  rd_mux = RD_W'({line_q[LO_W-1:0], 6'b0, chan_q});
      OFS_SYN:  rd_mux = RD_W'(syn_q);
      OFS_EXT:  rd_mux = RD_W'(line_q[LINE_W-1]);
      OFS_STAT: rd_mux = RD_W'(stat_q);
      OFS_ENA:  rd_mux = RD_W'(ena_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ena_q    <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_en && reg_addr == OFS_ENA) ena_q <= wr_data & EVT_MASK;
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

  p_rd_valid_r11: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  p_ena_mask_r9: assert property (@(posedge clk) disable iff (rst)
    (ena_q & ~EVT_MASK) == '0);
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W  = 33,
  parameter int GRAIN_L = 7,
  parameter int SYN_W   = 8,
  parameter int REG_W   = 16,
  parameter int RD_W    = 32,
  localparam int LINE_W = ADDR_W - GRAIN_L
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_evt,
  input  logic              ue_evt,
  input  logic [LINE_W-1:0] err_line,
  input  logic              err_chan,
  input  logic [SYN_W-1:0]  err_syn,
  input  logic              rfto_evt,
  input  logic              lock_evt,
  input  logic              therm_evt,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        reg_addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [RD_W-1:0]   rd_data,
  output logic              rd_valid,
  output logic              serr
);
  logic [REG_W-1:0]  ev, clr, ena_q, stat_q, stat_post;
  logic [LINE_W-1:0] line_q;
  logic              chan_q;
  logic [SYN_W-1:0]  syn_q;

  always_comb begin
    ev          = '0;
    ev[B_CE]    = ce_evt;
    ev[B_UE]    = ue_evt;
    ev[B_RFTO]  = rfto_evt;
    ev[B_LOCK]  = lock_evt;
    ev[B_THERM] = therm_evt;
  end

  ecc_stat_reg #(.REG_W(REG_W)) u_stat (
    .clk(clk), .rst(rst), .ev(ev), .clr(clr), .ena(ena_q),
    .stat_q(stat_q), .stat_post(stat_post), .serr(serr)
  );

  ecc_capture #(.LINE_W(LINE_W), .SYN_W(SYN_W)) u_cap (
    .clk(clk), .rst(rst), .ce(ce_evt), .ue(ue_evt),
    .line_i(err_line), .chan_i(err_chan), .syn_i(err_syn),
    .logged(stat_post[1:0]),
    .line_q(line_q), .chan_q(chan_q), .syn_q(syn_q)
  );

  ecc_reg_port #(.LINE_W(LINE_W), .SYN_W(SYN_W), .REG_W(REG_W), .RD_W(RD_W)) u_port (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .stat_q(stat_q), .line_q(line_q), .chan_q(chan_q),
    .syn_q(syn_q), .clr(clr), .ena_q(ena_q), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  p_rst_quiet_r1: assert property (@(posedge clk) rst |=> (!serr && !rd_valid));
endmodule

// File: tb/test_ecc_err_log.sv
module test_ecc_err_log;
  logic clk = 1'b0, rst = 1'b1;
  logic ce, ue, rfto, lk, th, chan, wr_en, rd_en;
  logic [25:0] line;
  logic [7:0] syn, raddr;
  logic [15:0] wdata;
  logic [31:0] rd_data;
  logic rd_valid, serr;
  int checks = 0, errors = 0;
  bit done = 0;
  string ovr = "";

  logic [15:0] m_stat, m_ena;
  logic [25:0] m_line;
  logic m_chan;
  logic [7:0] m_syn;

  always #10 clk = ~clk;

  ecc_err_log i_ecc_err_log (
    .clk(clk), .rst(rst), .ce_evt(ce), .ue_evt(ue), .err_line(line), .err_chan(chan),
    .err_syn(syn), .rfto_evt(rfto), .lock_evt(lk), .therm_evt(th), .wr_en(wr_en),
    .rd_en(rd_en), .reg_addr(raddr), .wr_data(wdata), .rd_data(rd_data),
    .rd_valid(rd_valid), .serr(serr)
  );

  function automatic logic [31:0] model_read(logic [7:0] a);
    case (a)
      8'h58: return {m_line[24:0], 6'b0, m_chan};
      8'h5C: return {24'b0, m_syn};
      8'h70: return {31'b0, m_line[25]};
      8'hC8: return {16'b0, m_stat};
      8'hCA: return {16'b0, m_ena};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] a);
    if (ovr != "") return ovr;
    case (a)
      8'hC8: return "R2 status";
      8'h58, 8'h70: return "R5 pointer";
      8'h5C: return "R6 syndrome";
      8'hCA: return "R9 enable";
      default: return "R11 unmapped";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ce = 0; ue = 0; rfto = 0; lk = 0; th = 0; wr_en = 0; rd_en = 0;
    raddr = 8'h00; wdata = 16'h0; line = '0; chan = 0; syn = 8'h0;
  endtask

  task automatic step();
    logic [15:0] clr, ev, post, nstat;
    logic [31:0] rexp;
    logic exp_serr, exp_rv, take;
    string tg;
    rexp = model_read(raddr);
    exp_rv = rd_en;
    tg = tag_of(raddr);
    clr = (wr_en && raddr == 8'hC8) ? (wdata & 16'h0B03) : 16'h0;
    ev = 16'h0;
    ev[0] = ce; ev[1] = ue; ev[8] = rfto; ev[9] = lk; ev[11] = th;
    post = m_stat & ~clr;
    nstat = post | ev;
    take = ue ? !post[1] : (ce && post[1:0] == 2'b00);
    exp_serr = |(nstat & ~m_stat & m_ena);
    if (take) begin m_line = line; m_chan = chan; m_syn = syn; end
    m_stat = nstat;
    if (wr_en && raddr == 8'hCA) m_ena = wdata & 16'h0B03;
    @(posedge clk);
    @(negedge clk);
    chk("R10 serr", {31'b0, serr}, {31'b0, exp_serr});
    chk("R11 rd_valid", {31'b0, rd_valid}, {31'b0, exp_rv});
    if (exp_rv) chk(tg, rd_data, rexp);
    idle();
  endtask

  task automatic rd(logic [7:0] a);
    rd_en = 1; raddr = a; step();
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    wr_en = 1; raddr = a; wdata = d; step();
  endtask

  task automatic err(bit u, logic [25:0] l, bit c, logic [7:0] s);
    ce = !u; ue = u; line = l; chan = c; syn = s; step();
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    idle();
    m_stat = 0; m_ena = 0; m_line = 0; m_chan = 0; m_syn = 0;
    repeat (3) @(negedge clk);
    chk("R1 serr in reset", {31'b0, serr}, 32'h0);
    chk("R1 rd_valid in reset", {31'b0, rd_valid}, 32'h0);
    rst = 0;
    ovr = "R1 reset value";
    rd(8'h58); rd(8'h5C); rd(8'h70); rd(8'hC8); rd(8'hCA);

    ovr = "R7 first capture";
    err(0, 26'h2ABCDEF, 1, 8'h3C); rd(8'h58); rd(8'h70); rd(8'h5C);
    ovr = "R8 ce keeps ce";
    err(0, 26'h0000011, 0, 8'h11); rd(8'h58); rd(8'h5C);
    ovr = "R8 ue replaces ce";
    err(1, 26'h1234567, 0, 8'hA5); rd(8'h58); rd(8'h5C); rd(8'h70);
    ovr = "R8 ce keeps ue";
    err(0, 26'h3FFFFFF, 1, 8'hFF); rd(8'h58); rd(8'h5C);
    ovr = "R8 ue keeps ue";
    err(1, 26'h0F0F0F0, 1, 8'h77); rd(8'h5C);

    ovr = "R3 partial clear";
    wr(8'hC8, 16'h0001); rd(8'hC8);
    wr(8'hC8, 16'hF4FC); rd(8'hC8);
    wr(8'hC8, 16'hFFFF); rd(8'hC8);

    ovr = "R9 enable mask";
    wr(8'hCA, 16'hFFFF); rd(8'hCA);
    ovr = "R4 event beats clear";
    ce = 1; line = 26'h5; syn = 8'h21; step();
    ce = 1; wr_en = 1; raddr = 8'hC8; wdata = 16'h0001; step(); rd(8'hC8);

    ovr = "R10 disabled event";
    wr(8'hC8, 16'hFFFF); wr(8'hCA, 16'h0800);
    lk = 1; step(); th = 1; step(); th = 1; step(); rd(8'hC8);

    ovr = "R11 read-only write";
    wr(8'h58, 16'hFFFF); wr(8'h5C, 16'hFFFF); wr(8'h10, 16'hFFFF);
    rd(8'h58); rd(8'h5C); rd(8'h10);

    ovr = "";
    for (int i = 0; i < 3000; i++) begin
      ce = ($urandom_range(7) == 0); ue = ($urandom_range(11) == 0);
      rfto = ($urandom_range(15) == 0); lk = ($urandom_range(15) == 0);
      th = ($urandom_range(15) == 0);
      line = 26'($urandom); chan = 1'($urandom); syn = 8'($urandom);
      rd_en = ($urandom_range(1) == 0);
      wr_en = ($urandom_range(3) == 0);
      case ($urandom_range(6))
        0: raddr = 8'h58; 1: raddr = 8'h5C; 2: raddr = 8'h70;
        3, 4: raddr = 8'hC8; 5: raddr = 8'hCA; default: raddr = 8'h5A;
      endcase
      wdata = 16'($urandom);
      step();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule